// File: doc/BRIEF.md
# Framed Streaming CRC-16 Generator

This block computes a 16-bit cyclic redundancy checksum over a framed message stream, several message bits per clock, and emits the message followed by its checksum. The upstream source presents one data word per cycle, qualified by a valid strobe. It marks the first word of a frame with a start strobe and the last word with an end strobe. The block repeats every message word unchanged after a fixed delay. It then appends the finished checksum as a short burst of extra words of the same width. The output end strobe marks the last of these words.

The divisor is x^16 + x^12 + x^5 + 1, written 0x1021 without its top term. The register is preset to all ones for every frame. Message bits enter at the register's high end, and no zero padding is shifted in. The result is inverted before it is sent. The word width is a build-time parameter. The only legal widths are those that divide sixteen evenly.

Top module: `crc16_stream_gen`

## Requirements
- R1: The checksum is the remainder of the message under divisor 0x1021 (x^16+x^12+x^5+1). Bits are taken most significant bit of each word first and shifted into the register's high end, with no zero bits appended to the message.
- R2: The remainder register is preset to 0xFFFF on the start word of every frame, whatever the earlier frames left in it.
- R3: The transmitted checksum is the final remainder XORed with 0xFFFF.
- R4: Every valid input word appears on out_data with out_valid high exactly LAT = 16/DATA_W + 2 cycles later, unchanged. out_start is high on the copy of the start word and low on all other message words.
- R5: The checksum follows in the NW = 16/DATA_W cycles immediately after the last message word. It is sent as NW valid words, with bits 15 down to 16-DATA_W in the first word, and out_start stays low on all of them.
- R6: out_end is high only on the last checksum word. It is low on the copy of the input end word.
- R7: DATA_W must be 1, 2, 4, 8 or 16, and any other value stops elaboration.
- R8: A new frame may begin NW idle input cycles after the previous end word. Each frame then gets its own correct checksum, even with two checksums in flight.
- R9: A synchronous reset, held high, drives out_valid, out_start and out_end low from the next cycle. It also discards any frame or checksum in progress.
- R10: Input cycles with in_valid low, inside or outside a frame, leave the checksum unchanged and produce a cycle with out_valid low LAT cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word qualifier |
| in_start | input | 1 | First word of a frame |
| in_end | input | 1 | Last word of a frame |
| in_data | input | DATA_W | Message word, bit DATA_W-1 sent first |
| out_valid | output | 1 | Output word qualifier |
| out_start | output | 1 | Copy of the frame's first word |
| out_end | output | 1 | Last checksum word |
| out_data | output | DATA_W | Message word or checksum slice |

## Verification
The bench builds the block with DATA_W = 4. This gives a four-word checksum tail and a six-cycle delay, so the order in which the checksum is shifted out and the word-by-word update of the remainder are both visible. At that width, one-word frames sent with the minimum gap put two finished checksums in flight at once. Bubbles inside frames, a known nine-byte message, constant all-zero and all-one payloads, and a reset in the middle of a tail are all reachable at this width.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_XOUT = 16'hFFFF;

  // Advance the remainder by the low nbits of word, highest of those bits first.
  function automatic logic [15:0] crc_advance(input logic [15:0] cur,
                                              input logic [15:0] word,
                                              input int unsigned nbits);
    logic [15:0] r;
    logic        fb;
    r = cur;
    for (int i = 15; i >= 0; i--) begin
      if (i < int'(nbits)) begin
        fb = r[15] ^ word[i];
        r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/crc16_align_pipe.sv
module crc16_align_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_start,
  input  logic         in_end,
  input  logic [W-1:0] in_data,
  output logic         dl_valid,
  output logic         dl_start,
  output logic         dl_end,
  output logic [W-1:0] dl_data
);

  logic [DEPTH-1:0] v_q, s_q, e_q;
  logic [W-1:0]     d_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      s_q <= '0;
      e_q <= '0;
    end else begin
      v_q <= {v_q[DEPTH-2:0], in_valid};
      s_q <= {s_q[DEPTH-2:0], in_valid & in_start};
      e_q <= {e_q[DEPTH-2:0], in_valid & in_end};
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) d_q[0] <= in_data;
    end else begin : g_body
      always_ff @(posedge clk) d_q[g] <= d_q[g-1];
    end
  end

  assign dl_valid = v_q[DEPTH-1];
  assign dl_start = s_q[DEPTH-1];
  assign dl_end   = e_q[DEPTH-1];
  assign dl_data  = d_q[DEPTH-1];

endmodule

// File: rtl/crc16_word_engine.sv
module crc16_word_engine
  import crc16_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_start,
  input  logic         in_end,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         capture,
  output logic [15:0]  csum_head
);

  logic        in_frame_q;
  logic [15:0] crc_q;
  logic        take;
  logic [15:0] base, nxt;

  assign take    = in_valid && (in_start || in_frame_q);
  assign base    = in_start ? CRC_SEED : crc_q;
  assign nxt     = crc_advance(base, 16'(in_data), W);
  assign capture = take && in_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      crc_q      <= CRC_SEED;
    end else if (take) begin
      crc_q      <= nxt;
      in_frame_q <= !in_end;
    end
  end

  // Two finished checksums may wait for the tail inserter at once.
  logic [15:0] slot_q [2];
  logic        wr_q, rd_q;
  logic [1:0]  occ_q;

  always_ff @(posedge clk) begin
    if (capture) slot_q[wr_q] <= nxt ^ CRC_XOUT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      occ_q <= 2'd0;
    end else begin
      if (capture) wr_q <= ~wr_q;
      if (pop)     rd_q <= ~rd_q;
      occ_q <= occ_q + 2'(capture) - 2'(pop);
    end
  end

  assign csum_head = slot_q[rd_q];

  // R8: the inserter only takes a checksum that has been stored.
  p_pop_has_slot_r8: assert property (@(posedge clk) disable iff (rst)
    pop |-> occ_q != 2'd0);

  // R8: back-to-back frames never overrun the two slots.
  p_slot_room_r8: assert property (@(posedge clk) disable iff (rst)
    capture |-> (occ_q != 2'd2 || pop));

endmodule

// File: rtl/crc16_tail_inserter.sv
module crc16_tail_inserter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dl_valid,
  input  logic         dl_start,
  input  logic         dl_end,
  input  logic [W-1:0] dl_data,
  input  logic [15:0]  csum_head,
  output logic         pop,
  output logic         tail_active,
  output logic         out_valid,
  output logic         out_start,
  output logic         out_end,
  output logic [W-1:0] out_data
);

  localparam int NW = 16 / W;
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0] left_q;
  logic [15:0]   sh_q;

  assign pop         = dl_valid && dl_end;
  assign tail_active = left_q != '0;

  always_ff @(posedge clk) begin
    if (rst)              left_q <= '0;
    else if (pop)         left_q <= CW'(NW);
    else if (tail_active) left_q <= left_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (pop)              sh_q <= csum_head;
    else if (tail_active) sh_q <= sh_q << W;
  end

  assign out_valid = dl_valid || tail_active;
  assign out_start = dl_valid && dl_start;
  assign out_end   = tail_active && (left_q == CW'(1));
  assign out_data  = tail_active ? sh_q[15 -: W] : dl_data;

  // R5: no start strobe while checksum words are on the output.
  p_start_quiet_tail_r5: assert property (@(posedge clk) disable iff (rst)
    tail_active |-> !out_start);

  // R8: the source kept its idle gap, so no message word collides with the tail.
  p_tail_no_collision_r8: assert property (@(posedge clk) disable iff (rst)
    tail_active |-> !dl_valid);

  // R6: the end strobe never sits on a message word.
  p_end_not_on_msg_r6: assert property (@(posedge clk) disable iff (rst)
    dl_valid |-> !out_end);

endmodule

// File: rtl/crc16_stream_gen.sv
module crc16_stream_gen #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_end,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_start,
  output logic              out_end,
  output logic [DATA_W-1:0] out_data
);

  localparam int NWORDS = 16 / DATA_W;
  localparam int LAT    = NWORDS + 2;

  // R7: only widths that split sixteen bits evenly are accepted.
  if (DATA_W != 1 && DATA_W != 2 && DATA_W != 4 && DATA_W != 8 && DATA_W != 16) begin : g_width_check
    $error("crc16_stream_gen: DATA_W must be 1, 2, 4, 8 or 16");
  end

  logic              dl_valid, dl_start, dl_end;
  logic [DATA_W-1:0] dl_data;
  logic              pop, capture, tail_active;
  logic [15:0]       csum_head;

  crc16_word_engine #(.W(DATA_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .in_end    (in_end),
    .in_data   (in_data),
    .pop       (pop),
    .capture   (capture),
    .csum_head (csum_head)
  );

  crc16_align_pipe #(.W(DATA_W), .DEPTH(LAT)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_end   (in_end),
    .in_data  (in_data),
    .dl_valid (dl_valid),
    .dl_start (dl_start),
    .dl_end   (dl_end),
    .dl_data  (dl_data)
  );

  crc16_tail_inserter #(.W(DATA_W)) u_tail (
    .clk         (clk),
    .rst         (rst),
    .dl_valid    (dl_valid),
    .dl_start    (dl_start),
    .dl_end      (dl_end),
    .dl_data     (dl_data),
    .csum_head   (csum_head),
    .pop         (pop),
    .tail_active (tail_active),
    .out_valid   (out_valid),
    .out_start   (out_start),
    .out_end     (out_end),
    .out_data    (out_data)
  );

  // R9: reset silences every output strobe one cycle later.
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_start && !out_end));

  // R8: a frame end reaches the tail inserter only after its checksum was captured.
  p_capture_before_pop_r8: assert property (@(posedge clk) disable iff (rst)
    capture |=> !tail_active || !pop);

endmodule

// File: tb/crc16_stream_gen_tb_top.sv
module crc16_stream_gen_tb_top;

  localparam int W   = 4;
  localparam int NW  = 16 / W;
  localparam int LAT = NW + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid, out_start, out_end;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;

  crc16_stream_gen #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_start(in_start), .in_end(in_end), .in_data(in_data),
    .out_valid(out_valid), .out_start(out_start), .out_end(out_end), .out_data(out_data)
  );

  typedef struct {
    bit           v, s, e;
    logic [W-1:0] d;
    string        tag;
  } exp_t;

  exp_t exp_q [int];
  int   cyc   = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   m_crc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model_bit(int c, bit b);
    int fb;
    fb = ((c >> 15) & 1) ^ int'(b);
    c  = (c << 1) & 'hFFFF;
    if (fb != 0) c = c ^ 'h1021;
    return c;
  endfunction

  task automatic put(int key, bit v, bit s, bit e, logic [W-1:0] d, string tag);
    exp_t x;
    x.v = v; x.s = s; x.e = e; x.d = d; x.tag = tag;
    exp_q[key] = x;
  endtask

  // Compare every output cycle against the reference schedule.
  always @(negedge clk) begin : cmp_blk
    exp_t x;
    if (cyc >= 1) begin
      if (exp_q.exists(cyc)) begin
        x = exp_q[cyc];
        exp_q.delete(cyc);
      end else begin
        x.v = 0; x.s = 0; x.e = 0; x.d = '0; x.tag = "R4/R10";
      end
      n_cmp++;
      if (out_valid !== x.v ||
          (x.v && (out_start !== x.s || out_end !== x.e || out_data !== x.d)) ||
          (!x.v && (out_start !== 1'b0 || out_end !== 1'b0))) begin
        n_bad++;
        $display("FAIL %s cycle %0d: got v=%0b s=%0b e=%0b d=%h, expected v=%0b s=%0b e=%0b d=%h",
                 x.tag, cyc, out_valid, out_start, out_end, out_data, x.v, x.s, x.e, x.d);
      end
    end
  end

  // Drive one input cycle and schedule what must come out.
  task automatic drive(bit v, bit s, bit e, logic [W-1:0] d, string mtag, string ttag);
    int fin;
    @(negedge clk);
    in_valid = v; in_start = s; in_end = e; in_data = d;
    if (v) begin
      if (s) m_crc = 'hFFFF;                         // R2 preset
      for (int b = W - 1; b >= 0; b--) m_crc = model_bit(m_crc, d[b]);  // R1
      put(cyc + LAT, 1, s, 0, d, mtag);              // R4
      if (e) begin
        fin = m_crc ^ 'hFFFF;                        // R3
        for (int k = 0; k < NW; k++)                 // R5, R6
          put(cyc + LAT + 1 + k, 1, 0, k == NW - 1, W'(fin >> (16 - W * (k + 1))), ttag);
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, W'($urandom), "R10", "R10");
  endtask

  // mode 0 random, 1 zeros, 2 ones; bub > 0 inserts a bubble every bub words.
  task automatic send_frame(int n, int mode, int bub, string ttag);
    logic [W-1:0] w;
    for (int i = 0; i < n; i++) begin
      if (bub > 0 && i > 0 && (i % bub) == 0)
        drive(0, 0, 0, W'($urandom), "R10", "R10");  // R10 bubble inside frame
      w = (mode == 1) ? '0 : (mode == 2) ? '1 : W'($urandom);
      drive(1, i == 0, i == n - 1, w, "R4", ttag);
    end
  endtask

  task automatic do_reset(int hold);
    int kill [$];
    @(negedge clk);
    rst = 1; in_valid = 0; in_start = 0; in_end = 0;
    foreach (exp_q[k]) if (k > cyc) kill.push_back(k);
    foreach (kill[i]) exp_q.delete(kill[i]);
    for (int k = 1; k <= hold + 1; k++) put(cyc + k, 0, 0, 0, '0, "R9");
    repeat (hold) @(negedge clk);
    rst = 0;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL R4 watchdog: got cycle %0d, expected finish before 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int kat;
    logic [7:0] txt [9];
    logic [W-1:0] nib;
    for (int i = 0; i < 9; i++) txt[i] = 8'h31 + 8'(i);
    // R9: outputs quiet while reset is held from time zero.
    for (int k = 1; k <= 4; k++) put(k, 0, 0, 0, '0, "R9");
    repeat (3) @(negedge clk);
    rst = 0;
    idle(3);

    // R1 R3 known answer for the nine digits 1..9: checksum 0xD64E.
    kat = 'hFFFF;
    for (int i = 0; i < 9; i++)
      for (int b = 7; b >= 0; b--) kat = model_bit(kat, txt[i][b]);
    n_cmp++;
    if ((kat ^ 'hFFFF) != 'hD64E) begin
      n_bad++;
      $display("FAIL R1 known answer: got %h, expected d64e", kat ^ 'hFFFF);
    end
    for (int i = 0; i < 18; i++) begin
      nib = (i % 2 == 0) ? W'(txt[i / 2] >> 4) : W'(txt[i / 2]);
      drive(1, i == 0, i == 17, nib, "R4", "R1/R3/R5/R6");
    end
    idle(NW);

    send_frame(1, 0, 0, "R5/R6");        // single-word frame
    idle(NW);
    send_frame(6, 1, 0, "R1/R3");        // all zeros
    idle(NW);
    send_frame(7, 2, 0, "R1/R2");        // all ones
    idle(NW);
    send_frame(9, 0, 3, "R10");          // bubbles inside the frame
    idle(NW + 3);

    // R8: one-word and short frames at the minimum gap.
    for (int f = 0; f < 5; f++) begin
      send_frame(1 + (f % 2), 0, 0, "R8");
      idle(NW);
    end
    idle(LAT);

    // R9: reset in the middle of a checksum tail, then a fresh frame (R2).
    send_frame(5, 0, 0, "R9");
    idle(LAT + 1);
    do_reset(2);
    idle(2);
    send_frame(4, 0, 0, "R2/R5");
    idle(NW);
    for (int f = 0; f < 6; f++) begin
      send_frame(2 + f, 0, (f % 3 == 2) ? 2 : 0, "R1/R2/R3");
      idle(NW + (f % 2));
    end
    idle(LAT + NW + 3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule